// File: doc/BRIEF.md
# NAND Flash Command Register and Readout Path

This block is a device-side model of the command decoder and read path of an 8-bit NAND flash interface. The host writes commands and addresses with the command-latch and address-latch strobes. The block captures each one on the rising edge of write enable while chip enable is low.

Four read modes exist:
- status read,
- EDC register read,
- a five-byte identification stream,
- plain data output, which drives nothing here because the array is not modelled.

A read mode is sticky: it stays in force until the next accepted command. Read data appears once both chip enable and read enable are low, so it follows whichever of the two falls last. The output enable tells the pad ring when to drive the bus.

A reset command clears the read mode and holds the ready output low for a configurable number of clock cycles. While that busy window runs, only the status-read command is accepted. A second reset does not restart the window. The EDC register contents arrive on a plain input, because the error checking itself is not modelled.

Top module: `nand_cmd_if`

## Requirements
- R1: After command 70h the read data is the status byte: bit 7 equals the write-protect input `wprot_n`, bit 6 equals `ready`, and bits 5..0 are 0. The byte follows those signals live during a single read cycle, with no strobe toggle needed.
- R2: `io_oe` is 1 only while `chip_en_n` and `rd_en_n` are both low and a read mode (status, EDC or ID) is active. Otherwise `io_oe` is 0 and `io_out` is 00h. Data is therefore presented from the later falling strobe.
- R3: A read mode persists across any number of read cycles until a new command is accepted. Command 00h selects plain data output, in which `io_oe` stays 0.
- R4: After command 7Bh the read data is the `edc_reg` input, tracked live, and the mode persists like status read.
- R5: Command 90h followed by one address cycle of 00h selects ID mode. Any other address value selects plain data output.
- R6: In ID mode, successive read cycles return `MAKER_ID`, then bytes 31..24, 23..16, 15..8 and 7..0 of `DEV_ID`. The sixth read wraps back to `MAKER_ID`.
- R7: An accepted command FFh clears the read mode to plain data output and drives `ready` low for exactly `TRST_CYC` clock cycles. `ready` is 1 after power-on reset.
- R8: Once the reset busy window has ended, status reads C0h when `wprot_n` is 1 and 40h when it is 0. During the busy window, bit 6 of the status byte reads 0.
- R9: A command FFh written while `ready` is low is ignored: the busy window is not lengthened.
- R10: While `ready` is low, every command other than 70h is ignored, and 70h is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low power-on reset |
| io_in | input | 8 | Command/address byte from the host |
| cmd_latch | input | 1 | High marks a write cycle as a command |
| addr_latch | input | 1 | High marks a write cycle as an address |
| chip_en_n | input | 1 | Active-low chip enable |
| wr_en_n | input | 1 | Active-low write enable; the rising edge captures the byte |
| rd_en_n | input | 1 | Active-low read enable |
| wprot_n | input | 1 | Active-low write protect |
| edc_reg | input | 8 | Current EDC register contents |
| io_out | output | 8 | Read data byte, 00h when not driven |
| io_oe | output | 1 | Drive enable for the data bus |
| ready | output | 1 | High when ready, low during the reset busy window |

## Verification
The embedded properties assume the host never raises command latch and address latch together. They also assume each write-enable pulse is held for at least one clock, and that read strobes stay steady for at least one clock between changes, so that every edge is sampled. The directed stimulus drives every strobe on the falling clock edge and holds each level for one or more full cycles. It keeps the two latch strobes mutually exclusive. It also issues the second reset and the blocked commands well inside the busy window, so that the window cannot expire before they are seen.

// File: rtl/nand_cmd_if.sv
module nand_cmd_if #(
  parameter int          TRST_CYC = 20,
  parameter logic [7:0]  MAKER_ID = 8'hAD,
  parameter logic [31:0] DEV_ID   = 32'h5AC3_1127
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] io_in,
  input  logic       cmd_latch,
  input  logic       addr_latch,
  input  logic       chip_en_n,
  input  logic       wr_en_n,
  input  logic       rd_en_n,
  input  logic       wprot_n,
  input  logic [7:0] edc_reg,
  output logic [7:0] io_out,
  output logic       io_oe,
  output logic       ready
);
  localparam int         CW       = $clog2(TRST_CYC + 1);
  localparam int         ID_LEN   = 5;
  localparam logic [7:0] OP_DATA  = 8'h00;
  localparam logic [7:0] OP_STAT  = 8'h70;
  localparam logic [7:0] OP_EDC   = 8'h7B;
  localparam logic [7:0] OP_ID    = 8'h90;
  localparam logic [7:0] OP_RESET = 8'hFF;

  typedef enum logic [2:0] {MD_DATA, MD_STAT, MD_EDC, MD_IDWAIT, MD_ID} mode_t;

  mode_t         mode;
  logic [CW-1:0] busy_cnt;
  logic [2:0]    id_idx;
  logic          we_q, rd_q;
  logic [7:0]    id_byte, rd_byte;

  assign ready = (busy_cnt == '0);

  wire we_rise = !we_q && wr_en_n && !chip_en_n;
  wire cmd_ev  = we_rise && cmd_latch && !addr_latch;
  wire addr_ev = we_rise && addr_latch && !cmd_latch;
  wire cmd_ok  = cmd_ev && (ready || io_in == OP_STAT);
  wire rst_go  = cmd_ok && io_in == OP_RESET;
  wire rd_act  = !chip_en_n && !rd_en_n;
  wire rd_end  = rd_q && !rd_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode     <= MD_DATA;
      busy_cnt <= '0;
      id_idx   <= '0;
      we_q     <= 1'b1;
      rd_q     <= 1'b0;
    end else begin
      we_q <= wr_en_n;
      rd_q <= rd_act;
      if (rst_go)      busy_cnt <= CW'(TRST_CYC);
      else if (!ready) busy_cnt <= busy_cnt - 1'b1;
      if (cmd_ok) begin
        id_idx <= '0;
        case (io_in)
          OP_STAT: mode <= MD_STAT;
          OP_EDC:  mode <= MD_EDC;
          OP_ID:   mode <= MD_IDWAIT;
          default: mode <= MD_DATA;
        endcase
      end else if (addr_ev && mode == MD_IDWAIT) begin
        id_idx <= '0;
        mode   <= (io_in == OP_DATA) ? MD_ID : MD_DATA;
      end else if (rd_end && mode == MD_ID) begin
        id_idx <= (id_idx == 3'(ID_LEN - 1)) ? 3'd0 : id_idx + 3'd1;
      end
    end
  end

  always_comb begin
    case (id_idx)
      3'd1:    id_byte = DEV_ID[31:24];
      3'd2:    id_byte = DEV_ID[23:16];
      3'd3:    id_byte = DEV_ID[15:8];
      3'd4:    id_byte = DEV_ID[7:0];
      default: id_byte = MAKER_ID;
    endcase
    case (mode)
      MD_STAT: rd_byte = {wprot_n, ready, 6'b0};
      MD_EDC:  rd_byte = edc_reg;
      MD_ID:   rd_byte = id_byte;
      default: rd_byte = 8'h00;
    endcase
  end

  assign io_oe  = rd_act && (mode == MD_STAT || mode == MD_EDC || mode == MD_ID);
  assign io_out = io_oe ? rd_byte : 8'h00;

  AST_OE_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
    io_oe |-> (!chip_en_n && !rd_en_n)); // R2
  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_ev && !addr_ev) |=> $stable(mode)); // R3
  AST_ID_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    id_idx < 3'(ID_LEN)); // R6
  AST_RESET_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    rst_go |=> (!ready && mode == MD_DATA)); // R7
  AST_NO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |=> (busy_cnt == $past(busy_cnt) - 1'b1)); // R9
  AST_BUSY_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ev && !ready && io_in != OP_STAT) |=> $stable(mode)); // R10
endmodule

// File: tb/nand_cmd_if_tb.sv
`timescale 1ns/1ps
module nand_cmd_if_tb;
  localparam int TRST = 20;
  logic clk = 0, rst_n = 0;
  logic [7:0] io_in = 0, edc_reg = 8'h3C;
  logic cmd_latch = 0, addr_latch = 0, chip_en_n = 1, wr_en_n = 1, rd_en_n = 1, wprot_n = 1;
  logic [7:0] io_out;
  logic io_oe, ready;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  nand_cmd_if #(.TRST_CYC(TRST)) u_dut (
    .clk(clk), .rst_n(rst_n), .io_in(io_in), .cmd_latch(cmd_latch), .addr_latch(addr_latch),
    .chip_en_n(chip_en_n), .wr_en_n(wr_en_n), .rd_en_n(rd_en_n), .wprot_n(wprot_n),
    .edc_reg(edc_reg), .io_out(io_out), .io_oe(io_oe), .ready(ready));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic write_cmd(logic [7:0] c);
    chip_en_n = 0; cmd_latch = 1; io_in = c; wr_en_n = 0;
    @(negedge clk) wr_en_n = 1;
    @(negedge clk) cmd_latch = 0;
  endtask

  task automatic write_addr(logic [7:0] a);
    chip_en_n = 0; addr_latch = 1; io_in = a; wr_en_n = 0;
    @(negedge clk) wr_en_n = 1;
    @(negedge clk) addr_latch = 0;
  endtask

  task automatic read_exp(string tag, logic [7:0] exp);
    chip_en_n = 0; rd_en_n = 0; #1;
    chk({tag, " oe"}, io_oe, 1);
    chk({tag, " data"}, io_out, exp);
    @(negedge clk) rd_en_n = 1;
    @(negedge clk);
  endtask

  task automatic read_none(string tag);
    chip_en_n = 0; rd_en_n = 0; #1;
    chk({tag, " oe"}, io_oe, 0);
    chk({tag, " data"}, io_out, 0);
    @(negedge clk) rd_en_n = 1;
    @(negedge clk);
  endtask

  task automatic wait_ready(output int n);
    n = 0;
    while (!ready) begin n++; @(negedge clk); end
  endtask

  task automatic t_power_on;
    chk("R7 ready after power-on", ready, 1);
    read_none("R2 no read mode");
  endtask

  task automatic t_status;
    write_cmd(8'h70);
    read_exp("R1 status", 8'hC0);
    rd_en_n = 0; wprot_n = 0; #1;
    chk("R1 live status", io_out, 8'h40);
    wprot_n = 1;
    @(negedge clk) rd_en_n = 1;
    @(negedge clk);
    read_exp("R3 sticky status", 8'hC0);
    write_cmd(8'h00);
    read_none("R3 data mode");
  endtask

  task automatic t_ce_last;
    write_cmd(8'h70);
    chip_en_n = 1;
    @(negedge clk) rd_en_n = 0; #1;
    chk("R2 chip enable high", io_oe, 0);
    @(negedge clk) chip_en_n = 0; #1;
    chk("R2 later strobe oe", io_oe, 1);
    chk("R2 later strobe data", io_out, 8'hC0);
    @(negedge clk) rd_en_n = 1;
    @(negedge clk);
  endtask

  task automatic t_edc;
    write_cmd(8'h7B);
    read_exp("R4 edc", 8'h3C);
    edc_reg = 8'hA5;
    read_exp("R4 edc live", 8'hA5);
  endtask

  task automatic t_id;
    logic [7:0] seq[7] = '{8'hAD, 8'h5A, 8'hC3, 8'h11, 8'h27, 8'hAD, 8'h5A};
    write_cmd(8'h90);
    write_addr(8'h00);
    for (int i = 0; i < 5; i++) read_exp("R5 id byte", seq[i]);
    for (int i = 5; i < 7; i++) read_exp("R6 id wrap", seq[i]);
    write_cmd(8'h90);
    write_addr(8'h01);
    read_none("R5 bad id address");
  endtask

  task automatic t_reset;
    int n;
    write_cmd(8'h70);
    write_cmd(8'hFF);
    wait_ready(n);
    chk("R7 busy length", n, TRST);
    read_none("R7 mode cleared");
    write_cmd(8'h70);
    read_exp("R8 status wp high", 8'hC0);
    wprot_n = 0;
    read_exp("R8 status wp low", 8'h40);
    wprot_n = 1;
  endtask

  task automatic t_reset_twice;
    int n;
    write_cmd(8'hFF);
    repeat (6) @(negedge clk);
    write_cmd(8'hFF);
    wait_ready(n);
    chk("R9 second reset ignored", n + 8, TRST);
  endtask

  task automatic t_busy_cmds;
    int n;
    write_cmd(8'hFF);
    write_cmd(8'h7B);
    read_none("R10 edc blocked");
    write_cmd(8'h70);
    read_exp("R8 R10 busy status", 8'h80);
    wait_ready(n);
    read_exp("R10 status after busy", 8'hC0);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_power_on();
    t_status();
    t_ce_last();
    t_edc();
    t_id();
    t_reset();
    t_reset_twice();
    t_busy_cmds();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule